// File: doc/BRIEF.md
# Saturating Step Up/Down Code Generator

This block computes the 10-bit code that drives a DAC register. A select input picks one of two sources. The first is a direct code that is written elsewhere and passed straight through. The second is a stepped code that two asynchronous push-style pins move up and down. Each accepted step on the raise pin adds a programmable increment, and each accepted step on the lower pin subtracts a programmable decrement. The stepped code never wraps: it stops at 0 and at the largest code.

A step counts only on a rising edge of one pin while the other pin is already high and stays high. Pulling both pins low together clears the stepped code to zero. Both pins pass through synchronizers into the clock domain. A rising edge takes effect on the stepped code three clock edges after the pin changes. The stepped code keeps running while the direct code is selected, so switching the select back shows whatever the steps have built up.

Top module: `step_code_gen`

## Requirements
- R1: With `sel_step` = 0, `dac_code` equals `direct_code` in the same cycle, and activity on `raise_pin` and `lower_pin` leaves `dac_code` unchanged.
- R2: With `sel_step` = 1, `dac_code` equals the running stepped code.
- R3: A rising edge on `raise_pin`, while `lower_pin` was high before the edge and is still high, adds `inc_size` to the stepped code.
- R4: A rising edge on `lower_pin`, while `raise_pin` was high before the edge and is still high, subtracts `dec_size` from the stepped code.
- R5: An up step whose sum would pass 1023 leaves the stepped code at 1023.
- R6: A down step whose difference would drop below 0 leaves the stepped code at 0.
- R7: When both pins are low after synchronization, the stepped code clears to 0.
- R8: Steps taken while `sel_step` = 0 still update the stepped code, and that result shows once `sel_step` returns to 1. Returning to 0 shows `direct_code` again.
- R9: After reset the stepped code is 0.
- R10: Falling edges, and rising edges of both pins in the same cycle, leave the stepped code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronized inside the block. |
| sel_step | input | 1 | 0 selects the direct code, 1 selects the stepped code |
| raise_pin | input | 1 | Asynchronous up-step pin |
| lower_pin | input | 1 | Asynchronous down-step pin |
| direct_code | input | 10 | Code passed through when `sel_step` = 0 |
| inc_size | input | 10 | Amount added per up step |
| dec_size | input | 10 | Amount subtracted per down step |
| dac_code | output | 10 | Code sent to the DAC register |

## Verification
The stepping function is driven with mixed up and down sequences that never clamp. These confirm that a single running sum matches the count-times-size formula. Other sequences climb past 1023 or fall below 0, to show clamping at each end. A zero-size case separates real steps from plain edge counting. A falling edge, and both pins rising together, are applied to show that only a qualified rising edge moves the code. Steps are also taken while the direct code is selected, to show that the stepped code keeps running but stays hidden until the select returns to 1.

// File: rtl/stepcode_pkg.sv
package stepcode_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INC   = 2'd1,
    ACT_DEC   = 2'd2,
    ACT_CLEAR = 2'd3
  } step_act_e;

endpackage

// File: rtl/stepcode_rst_sync.sv
module stepcode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/stepcode_pin_sync.sv
module stepcode_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic lvl,
  output logic lvl_prev
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl      = sync_q[STAGES-1];
  assign lvl_prev = prev_q;

endmodule

// File: rtl/stepcode_accum.sv
module stepcode_accum
  import stepcode_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_act_e         act,
  input  logic [CODE_W-1:0] inc_size,
  input  logic [CODE_W-1:0] dec_size,
  output logic [CODE_W-1:0] run_code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              code_en;
  logic [CODE_W:0]   sum_w;

  always_comb begin
    sum_w   = {1'b0, code_q} + {1'b0, inc_size};
    code_en = (act != ACT_HOLD);
    code_d  = code_q;
    unique case (act)
      ACT_INC:   code_d = sum_w[CODE_W] ? CODE_MAX : sum_w[CODE_W-1:0];
      ACT_DEC:   code_d = (dec_size > code_q) ? '0 : (code_q - dec_size);
      ACT_CLEAR: code_d = '0;
      default:   code_d = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign run_code = code_q;

endmodule

// File: rtl/step_code_gen.sv
module step_code_gen
  import stepcode_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_step,
  input  logic              raise_pin,
  input  logic              lower_pin,
  input  logic [CODE_W-1:0] direct_code,
  input  logic [CODE_W-1:0] inc_size,
  input  logic [CODE_W-1:0] dec_size,
  output logic [CODE_W-1:0] dac_code
);

  logic              rst_n_sync;
  logic              up_lvl, up_prev, dn_lvl, dn_prev;
  logic              up_rise, dn_rise;
  step_act_e         act;
  logic [CODE_W-1:0] run_code;

  stepcode_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  stepcode_pin_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .pin_async (raise_pin),
    .lvl       (up_lvl),
    .lvl_prev  (up_prev)
  );

  stepcode_pin_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .pin_async (lower_pin),
    .lvl       (dn_lvl),
    .lvl_prev  (dn_prev)
  );

  // A step needs the opposite pin high before and after the edge.
  always_comb begin
    up_rise = up_lvl & ~up_prev;
    dn_rise = dn_lvl & ~dn_prev;
    if (!up_lvl && !dn_lvl)                 act = ACT_CLEAR;
    else if (up_rise && dn_lvl && dn_prev)  act = ACT_INC;
    else if (dn_rise && up_lvl && up_prev)  act = ACT_DEC;
    else                                    act = ACT_HOLD;
  end

  stepcode_accum #(.CODE_W(CODE_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .act      (act),
    .inc_size (inc_size),
    .dec_size (dec_size),
    .run_code (run_code)
  );

  assign dac_code = sel_step ? run_code : direct_code;

endmodule

// File: rtl/step_code_gen_chk.sv
module step_code_gen_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              up_lvl,
  input logic              up_prev,
  input logic              dn_lvl,
  input logic              dn_prev,
  input logic [CODE_W-1:0] inc_size,
  input logic [CODE_W-1:0] dec_size,
  input logic [CODE_W-1:0] run_code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic both_low, up_ok, dn_ok;
  logic [CODE_W:0] wide_sum;

  always_comb begin
    both_low = !up_lvl && !dn_lvl;
    up_ok    = up_lvl && !up_prev && dn_lvl && dn_prev;
    dn_ok    = dn_lvl && !dn_prev && up_lvl && up_prev;
    wide_sum = {1'b0, run_code} + {1'b0, inc_size};
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    both_low |=> (run_code == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!both_low && !up_ok && !dn_ok) |=> $stable(run_code));

  p_up_grow_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (up_ok && !wide_sum[CODE_W]) |=> (run_code == $past(wide_sum[CODE_W-1:0])));

  p_down_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (dn_ok && (dec_size <= run_code)) |=> (run_code == $past(run_code - dec_size)));

  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (up_ok && wide_sum[CODE_W]) |=> (run_code == CODE_MAX));

  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (dn_ok && (dec_size > run_code)) |=> (run_code == '0));

endmodule

bind step_code_gen step_code_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .up_lvl     (up_lvl),
  .up_prev    (up_prev),
  .dn_lvl     (dn_lvl),
  .dn_prev    (dn_prev),
  .inc_size   (inc_size),
  .dec_size   (dec_size),
  .run_code   (run_code)
);

// File: tb/step_code_gen_tb.sv
module step_code_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_step;
  logic       raise_pin, lower_pin;
  logic [9:0] direct_code, inc_size, dec_size;
  logic [9:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  step_code_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_step    (sel_step),
    .raise_pin   (raise_pin),
    .lower_pin   (lower_pin),
    .direct_code (direct_code),
    .inc_size    (inc_size),
    .dec_size    (dec_size),
    .dac_code    (dac_code)
  );

  // {inc, dec, n_up, n_down, expected}: ups first, then downs
  localparam logic [37:0] VEC [0:6] = '{
    {10'd5,    10'd3,  4'd4, 4'd2, 10'd14},
    {10'd100,  10'd0,  4'd3, 4'd0, 10'd300},
    {10'd400,  10'd0,  4'd3, 4'd0, 10'd1023},
    {10'd1023, 10'd1,  4'd2, 4'd1, 10'd1022},
    {10'd10,   10'd7,  4'd1, 4'd3, 10'd0},
    {10'd0,    10'd0,  4'd3, 4'd3, 10'd0},
    {10'd200,  10'd50, 4'd2, 4'd5, 10'd150}
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_then_high();
    raise_pin = 1'b0; lower_pin = 1'b0; settle();
    raise_pin = 1'b1; lower_pin = 1'b1; settle();
  endtask

  task automatic pulse_up();
    raise_pin = 1'b0; settle();
    raise_pin = 1'b1; settle();
  endtask

  task automatic pulse_dn();
    lower_pin = 1'b0; settle();
    lower_pin = 1'b1; settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_step = 1'b1; raise_pin = 1'b1; lower_pin = 1'b1;
    direct_code = 10'd683; inc_size = 10'd7; dec_size = 10'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R9 reset code", dac_code, 10'd0);
    check("R10 joint rise after reset", dac_code, 10'd0);

    sel_step = 1'b0;
    #1 check("R1 direct pass", dac_code, 10'd683);
    pulse_up(); pulse_up(); pulse_up();
    check("R1 steps hidden", dac_code, 10'd683);
    sel_step = 1'b1;
    #1 check("R8 steps kept while direct", dac_code, 10'd21);
    sel_step = 1'b0;
    #1 check("R8 direct restored", dac_code, 10'd683);
    sel_step = 1'b1;
    raise_pin = 1'b0; settle();
    check("R10 falling edge ignored", dac_code, 10'd21);
    raise_pin = 1'b1; settle();
    check("R3 single up step", dac_code, 10'd28);
    raise_pin = 1'b0; lower_pin = 1'b0; settle();
    check("R7 both low clears", dac_code, 10'd0);
    raise_pin = 1'b1; lower_pin = 1'b1; settle();
    check("R10 joint rise no step", dac_code, 10'd0);

    for (int i = 0; i < 7; i++) begin
      clear_then_high();
      inc_size = VEC[i][37:28];
      dec_size = VEC[i][27:18];
      for (int u = 0; u < int'(VEC[i][17:14]); u++) pulse_up();
      for (int d = 0; d < int'(VEC[i][13:10]); d++) pulse_dn();
      check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), dac_code, VEC[i][9:0]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule